// File: doc/BRIEF.md
# Codec Command Ring Fetch Engine

This block feeds codec commands from system memory to the link side of an audio controller. Software fills a 256-slot ring of 32-bit command words (verbs) and advances a write pointer. While the engine is running it pulls verbs out one at a time over a simple memory-read request/response port. Each verb is split into a codec address, a node ID and a 20-bit payload, and presented on a valid/ready command port. Verbs that use indirect node addressing, and verbs aimed at a codec that is not in the presence mask, are consumed from the ring and discarded.

A separate single-word immediate path lets software push one verb without the ring. Once armed it is serviced before any ring activity. Ring fetching also holds off while the response side reports that its counter has reached the programmed interrupt-count threshold. Configuration comes through a small register-write port. The read pointer is visible as an output so software can follow progress.

Top module: `cmd_ring_engine`

## Requirements
- R1: After reset the read pointer is 0, the run bit and the immediate busy flag are clear, and neither a memory request nor a command is presented.
- R2: Ring fetches start only while the run bit (select 4, data bit 0) is 1 and the read pointer differs from the write pointer (select 2, data bits 7:0). A write that raises the run bit or moves the write pointer resumes fetching.
- R3: Before each fetch the read pointer is incremented modulo 256, and the request address is {upper base (select 1), lower base (select 0)} + 4 × the new read pointer.
- R4: A dispatched verb appears with codec address = bits 31:28, node ID = bits 26:20 and payload = bits 19:0, and stays stable while the command is held off by ready.
- R5: A verb with bit 27 set is not dispatched, but its ring slot is still consumed.
- R6: A verb whose codec address selects a 0 bit of codec_present is not dispatched, but its ring slot is still consumed.
- R7: No ring fetch starts while rsp_count equals rsp_thresh. Fetching resumes once they differ.
- R8: Writing 1 to data bit 0 at select 6 arms the immediate word (select 5). It is taken ahead of any pending ring verb, regardless of the run bit or the threshold stall. The busy flag clears once the word is dispatched or rejected under R5/R6.
- R9: Only one verb is in flight. No memory request is presented while a command is pending, and a new fetch waits until the previous verb has been accepted or dropped.
- R10: A write to the read pointer (select 3, data bits 7:0) loads it only while the run bit is 0. While the run bit is 1 the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 3 | Register select |
| reg_wr_data | input | 32 | Register write data |
| codec_present | input | 16 | One bit per codec address that exists |
| rsp_count | input | 8 | Current response counter |
| rsp_thresh | input | 8 | Programmed response interrupt count |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Byte address of the verb |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Verb word, little-endian |
| cmd_valid | output | 1 | Command presented |
| cmd_ready | input | 1 | Command accepted |
| cmd_cad | output | 4 | Codec address |
| cmd_nid | output | 7 | Node ID |
| cmd_payload | output | 20 | Verb payload |
| ring_rp | output | 8 | Current read pointer |
| imm_busy | output | 1 | Immediate word pending |

## Verification
The case hardest to reach from the ports is an immediate word competing with ring verbs. Arming the word while the engine is idle never exercises the ordering. To create the conflict, the bench holds cmd_ready low so that a ring verb sits on the command port with further verbs queued behind it. It then arms the immediate word and releases ready, and expects the held ring verb, then the immediate word, then the rest of the ring. Pointer wrap-around is covered by sweeps that start near slot 255 and by a 255-verb fill of the whole ring.

// File: rtl/cmd_ring_pkg.sv
// Shared constants and verb field helpers for the command ring engine.
// Assumes 32-bit verbs whose layout is fixed by the link protocol.
package cmd_ring_pkg;

    localparam int VERB_W    = 32;
    localparam int CAD_W     = 4;
    localparam int NID_W     = 7;
    localparam int PAYLOAD_W = 20;
    localparam int SEL_W     = 3;

    // register select codes
    localparam logic [SEL_W-1:0] SEL_BASE_LO  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_BASE_HI  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_WR_PTR   = 3'd2;
    localparam logic [SEL_W-1:0] SEL_RD_PTR   = 3'd3;
    localparam logic [SEL_W-1:0] SEL_CONTROL  = 3'd4;
    localparam logic [SEL_W-1:0] SEL_IMM_WORD = 3'd5;
    localparam logic [SEL_W-1:0] SEL_IMM_GO   = 3'd6;

    typedef struct packed {
        logic [CAD_W-1:0]     cad;
        logic                 indirect;
        logic [NID_W-1:0]     nid;
        logic [PAYLOAD_W-1:0] payload;
    } verb_t;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_REQ,
        FS_WAIT,
        FS_CHECK,
        FS_ISSUE
    } fetch_state_t;

endpackage

// File: rtl/cmd_ring_regs.sv
// Configuration registers of the command ring engine.
// Holds the ring base, write pointer, run bit and immediate word/busy flag.
// A read pointer write is turned into a load pulse, and only while stopped.
module cmd_ring_regs
    import cmd_ring_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int PTR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [31:0]       wr_data,
    input  logic              imm_done,
    output logic [ADDR_W-1:0] ring_base,
    output logic [PTR_W-1:0]  wr_ptr,
    output logic              run,
    output logic [VERB_W-1:0] imm_word,
    output logic              imm_busy,
    output logic              rp_load,
    output logic [PTR_W-1:0]  rp_load_val
);

    localparam int HI_W = ADDR_W - 32;

    logic [31:0]   base_lo;
    logic [HI_W-1:0] base_hi;

    // Register updates from the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_lo  <= '0;
            base_hi  <= '0;
            wr_ptr   <= '0;
            run      <= 1'b0;
            imm_word <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_BASE_LO:  base_lo  <= wr_data;
                SEL_BASE_HI:  base_hi  <= wr_data[HI_W-1:0];
                SEL_WR_PTR:   wr_ptr   <= wr_data[PTR_W-1:0];
                SEL_CONTROL:  run      <= wr_data[0];
                SEL_IMM_WORD: imm_word <= wr_data;
                default: ;
            endcase
        end
    end

    // Immediate busy flag: armed by a go write, cleared when the word is consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imm_busy <= 1'b0;
        end else begin
            imm_busy <= (imm_busy & ~imm_done) |
                        (wr_en && wr_sel == SEL_IMM_GO && wr_data[0]);
        end
    end

    // Read pointer load request, honoured only while the ring is stopped.
    always_comb begin
        rp_load     = wr_en && (wr_sel == SEL_RD_PTR) && !run;
        rp_load_val = wr_data[PTR_W-1:0];
        ring_base   = {base_hi, base_lo};
    end

endmodule

// File: rtl/cmd_verb_decode.sv
// Splits a verb into its fields and decides whether it may be dispatched.
// Rejects indirect node addressing and codecs absent from the presence mask.
module cmd_verb_decode
    import cmd_ring_pkg::*;
#(
    parameter int NUM_CODECS = 16
) (
    input  logic [VERB_W-1:0]     verb,
    input  logic [NUM_CODECS-1:0] present,
    output verb_t                 fields,
    output logic                  accept
);

    // Field split and acceptance check.
    always_comb begin
        fields = verb_t'(verb);
        accept = !fields.indirect && present[fields.cad];
    end

endmodule

// File: rtl/cmd_ring_fetch.sv
// Fetch sequencer: one verb at a time from the immediate word or the ring.
// Assumes at most one memory response per accepted request, in order.
module cmd_ring_fetch
    import cmd_ring_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int PTR_W      = 8,
    parameter int CNT_W      = 8,
    parameter int NUM_CODECS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     ring_base,
    input  logic [PTR_W-1:0]      wr_ptr,
    input  logic                  run,
    input  logic [VERB_W-1:0]     imm_word,
    input  logic                  imm_busy,
    input  logic                  rp_load,
    input  logic [PTR_W-1:0]      rp_load_val,
    input  logic [CNT_W-1:0]      rsp_count,
    input  logic [CNT_W-1:0]      rsp_thresh,
    input  logic [NUM_CODECS-1:0] codec_present,
    output logic                  imm_done,
    output logic [PTR_W-1:0]      rd_ptr,
    output logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    output logic [ADDR_W-1:0]     mem_req_addr,
    input  logic                  mem_rsp_valid,
    input  logic [VERB_W-1:0]     mem_rsp_data,
    output logic                  cmd_valid,
    input  logic                  cmd_ready,
    output logic [CAD_W-1:0]      cmd_cad,
    output logic [NID_W-1:0]      cmd_nid,
    output logic [PAYLOAD_W-1:0]  cmd_payload
);

    fetch_state_t      state;
    logic [VERB_W-1:0] verb_q;
    logic              from_imm;
    logic [PTR_W-1:0]  rp_next;
    logic              ring_go;
    verb_t             fields;
    logic              accept;

    cmd_verb_decode #(.NUM_CODECS(NUM_CODECS)) u_decode (
        .verb    (verb_q),
        .present (codec_present),
        .fields  (fields),
        .accept  (accept)
    );

    // Next pointer and ring start condition.
    always_comb begin
        rp_next = rd_ptr + 1'b1;
        ring_go = run && (rd_ptr != wr_ptr) && (rsp_count != rsp_thresh);
    end

    // Sequencer: immediate word first, then one ring verb per pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= FS_IDLE;
            verb_q       <= '0;
            from_imm     <= 1'b0;
            rd_ptr       <= '0;
            mem_req_addr <= '0;
        end else begin
            if (rp_load) begin
                rd_ptr <= rp_load_val;
            end
            case (state)
                FS_IDLE: begin
                    if (imm_busy) begin
                        verb_q   <= imm_word;
                        from_imm <= 1'b1;
                        state    <= FS_CHECK;
                    end else if (ring_go) begin
                        rd_ptr       <= rp_next;
                        mem_req_addr <= ring_base + ADDR_W'({rp_next, 2'b00});
                        state        <= FS_REQ;
                    end
                end
                FS_REQ: begin
                    if (mem_req_ready) state <= FS_WAIT;
                end
                FS_WAIT: begin
                    if (mem_rsp_valid) begin
                        verb_q   <= mem_rsp_data;
                        from_imm <= 1'b0;
                        state    <= FS_CHECK;
                    end
                end
                FS_CHECK: begin
                    state <= accept ? FS_ISSUE : FS_IDLE;
                end
                FS_ISSUE: begin
                    if (cmd_ready) state <= FS_IDLE;
                end
                default: state <= FS_IDLE;
            endcase
        end
    end

    // Port drive and immediate completion pulse.
    always_comb begin
        mem_req_valid = (state == FS_REQ);
        cmd_valid     = (state == FS_ISSUE);
        cmd_cad       = fields.cad;
        cmd_nid       = fields.nid;
        cmd_payload   = fields.payload;
        imm_done      = from_imm && (((state == FS_CHECK) && !accept) ||
                                     ((state == FS_ISSUE) && cmd_ready));
    end

    // R3: the pointer only ever moves by one step unless loaded.
    p_rp_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_ptr != $past(rd_ptr)) && !$past(rp_load)) |-> (rd_ptr == $past(rd_ptr) + 1'b1));

    // R2: a stopped ring with no immediate word starts no fetch.
    p_no_fetch_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == FS_IDLE) && !run && !imm_busy) |=> !mem_req_valid);

    // R7: threshold reached blocks a new fetch.
    p_stall_thresh_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == FS_IDLE) && !imm_busy && (rsp_count == rsp_thresh)) |=> !mem_req_valid);

    // R8: a pending immediate word wins over the ring.
    p_imm_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == FS_IDLE) && imm_busy) |=> !mem_req_valid);

    // R4 / R9: a held command keeps its fields.
    p_cmd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_cad) &&
                                       $stable(cmd_nid) && $stable(cmd_payload)));

    // R6: only present codecs are addressed.
    p_present_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> codec_present[cmd_cad]);

endmodule

// File: rtl/cmd_ring_engine.sv
// Top of the command ring engine: registers plus fetch sequencer.
// Assumes the memory port returns one response per accepted request.
module cmd_ring_engine
    import cmd_ring_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int PTR_W  = 8,
    parameter int CNT_W  = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_wr_en,
    input  logic [SEL_W-1:0]             reg_wr_sel,
    input  logic [31:0]                  reg_wr_data,
    input  logic [(1<<CAD_W)-1:0]        codec_present,
    input  logic [CNT_W-1:0]             rsp_count,
    input  logic [CNT_W-1:0]             rsp_thresh,
    output logic                         mem_req_valid,
    input  logic                         mem_req_ready,
    output logic [ADDR_W-1:0]            mem_req_addr,
    input  logic                         mem_rsp_valid,
    input  logic [VERB_W-1:0]            mem_rsp_data,
    output logic                         cmd_valid,
    input  logic                         cmd_ready,
    output logic [CAD_W-1:0]             cmd_cad,
    output logic [NID_W-1:0]             cmd_nid,
    output logic [PAYLOAD_W-1:0]         cmd_payload,
    output logic [PTR_W-1:0]             ring_rp,
    output logic                         imm_busy
);

    localparam int NUM_CODECS = 1 << CAD_W;

    logic [ADDR_W-1:0] ring_base;
    logic [PTR_W-1:0]  wr_ptr;
    logic              run;
    logic [VERB_W-1:0] imm_word;
    logic              imm_done;
    logic              rp_load;
    logic [PTR_W-1:0]  rp_load_val;

    cmd_ring_regs #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr_en),
        .wr_sel      (reg_wr_sel),
        .wr_data     (reg_wr_data),
        .imm_done    (imm_done),
        .ring_base   (ring_base),
        .wr_ptr      (wr_ptr),
        .run         (run),
        .imm_word    (imm_word),
        .imm_busy    (imm_busy),
        .rp_load     (rp_load),
        .rp_load_val (rp_load_val)
    );

    cmd_ring_fetch #(
        .ADDR_W(ADDR_W), .PTR_W(PTR_W), .CNT_W(CNT_W), .NUM_CODECS(NUM_CODECS)
    ) u_fetch (
        .clk           (clk),
        .rst_n         (rst_n),
        .ring_base     (ring_base),
        .wr_ptr        (wr_ptr),
        .run           (run),
        .imm_word      (imm_word),
        .imm_busy      (imm_busy),
        .rp_load       (rp_load),
        .rp_load_val   (rp_load_val),
        .rsp_count     (rsp_count),
        .rsp_thresh    (rsp_thresh),
        .codec_present (codec_present),
        .imm_done      (imm_done),
        .rd_ptr        (ring_rp),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .cmd_valid     (cmd_valid),
        .cmd_ready     (cmd_ready),
        .cmd_cad       (cmd_cad),
        .cmd_nid       (cmd_nid),
        .cmd_payload   (cmd_payload)
    );

endmodule

// File: tb/cmd_ring_engine_test.sv
`timescale 1ns/1ps
module cmd_ring_engine_test;

    localparam logic [63:0] BASE = 64'h0000_0012_3456_7000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_wr_sel = '0;
    logic [31:0] reg_wr_data = '0;
    logic [15:0] codec_present = 16'hffff;
    logic [7:0]  rsp_count = 8'd0;
    logic [7:0]  rsp_thresh = 8'd200;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [63:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        cmd_valid;
    logic        cmd_ready = 1'b1;
    logic [3:0]  cmd_cad;
    logic [6:0]  cmd_nid;
    logic [19:0] cmd_payload;
    logic [7:0]  ring_rp;
    logic        imm_busy;

    cmd_ring_engine uut (.*);

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit hold_ready = 1'b0;
    bit jitter = 1'b0;
    bit overlap_seen = 1'b0;
    logic [7:0]  exp_idx = '0;
    logic [31:0] ring_mem [256];
    logic [30:0] obs_q[$];
    logic [30:0] exp_q[$];

    // memory model and ready pattern, updated just after the edge
    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_rsp_valid <= mem_req_valid && mem_req_ready;
        mem_rsp_data  <= ring_mem[8'((mem_req_addr - BASE) >> 2)];
        cmd_ready     <= hold_ready ? 1'b0 : (jitter ? (cyc % 3 != 1) : 1'b1);
        mem_req_ready <= jitter ? (cyc % 4 != 2) : 1'b1;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // monitor away from the edge: command log, address check, overlap
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_valid && cmd_ready) obs_q.push_back({cmd_cad, cmd_nid, cmd_payload});
            if (cmd_valid && mem_req_valid) overlap_seen = 1'b1;
            if (mem_req_valid && mem_req_ready) begin
                exp_idx = exp_idx + 8'd1;
                chk(mem_req_addr == BASE + 64'(exp_idx) * 4, "R3", "fetch address",
                    mem_req_addr, BASE + 64'(exp_idx) * 4);
            end
        end
    end

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_sel = sel; reg_wr_data = data;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    function automatic logic [31:0] make_verb(int t, int i);
        logic [3:0]  c = 4'((i * 3 + t) % 16);
        logic        ind = ((i + t) % 11) == 5;
        logic [6:0]  n = 7'(i * 5 + t);
        logic [19:0] p = 20'(i * 977 + t * 31);
        return {c, ind, n, p};
    endfunction

    function automatic logic [30:0] pack(logic [31:0] v);
        return {v[31:28], v[26:20], v[19:0]};
    endfunction

    task automatic wait_rp(input logic [7:0] target);
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            if (ring_rp == target) break;
        end
        repeat (40) @(negedge clk);
    endtask

    task automatic compare(input string req, input string what);
        chk(obs_q.size() == exp_q.size(), req, {what, " count"}, obs_q.size(), exp_q.size());
        for (int k = 0; k < exp_q.size() && k < obs_q.size(); k++)
            chk(obs_q[k] == exp_q[k], req, what, obs_q[k], exp_q[k]);
    endtask

    // one ring pass: load pointer, fill, run to empty, compare
    task automatic ring_pass(input int t, input logic [7:0] start, input int len,
                             input logic [15:0] mask, input string req);
        logic [7:0] idx;
        wr(3'd4, 0);
        wr(3'd3, 32'(start));
        codec_present = mask;
        exp_q.delete(); obs_q.delete();
        for (int i = 1; i <= len; i++) begin
            idx = 8'(int'(start) + i);
            ring_mem[idx] = make_verb(t, i);
            if (!ring_mem[idx][27] && mask[ring_mem[idx][31:28]])
                exp_q.push_back(pack(ring_mem[idx]));
        end
        exp_idx = start;
        wr(3'd2, 32'(8'(int'(start) + len)));
        wr(3'd4, 1);
        wait_rp(8'(int'(start) + len));
        compare(req, "ring verbs R4 R5 R6");
        chk(ring_rp == 8'(int'(start) + len), "R3", "final read pointer",
            ring_rp, 8'(int'(start) + len));
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] rp_before;
        for (int i = 0; i < 256; i++) ring_mem[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ring_rp == 0, "R1", "reset read pointer", ring_rp, 0);
        chk(!mem_req_valid && !cmd_valid, "R1", "reset idle ports",
            {mem_req_valid, cmd_valid}, 0);
        chk(!imm_busy, "R1", "reset immediate busy", imm_busy, 0);

        wr(3'd0, BASE[31:0]);
        wr(3'd1, BASE[63:32]);

        // R2: write pointer moved, run clear -> nothing happens
        obs_q.delete();
        ring_mem[1] = 32'h1010_0001;
        wr(3'd2, 3);
        repeat (30) @(negedge clk);
        chk(ring_rp == 0, "R2", "no fetch while stopped (rp)", ring_rp, 0);
        chk(obs_q.size() == 0, "R2", "no command while stopped", obs_q.size(), 0);
        wr(3'd2, 0);

        // R2 R3 R4: plain run, all valid
        ring_pass(0, 8'd0, 5, 16'hffff, "R2");
        // R10: read pointer write ignored while running
        wr(3'd3, 32'h40);
        repeat (10) @(negedge clk);
        chk(ring_rp == 8'd5, "R10", "rp write ignored while run", ring_rp, 5);

        // R3 wrap, R5 R6 drops, backpressure sweep
        for (int t = 1; t <= 6; t++) begin
            jitter = (t % 2) == 0;
            ring_pass(t, 8'(250 + t), 9 + t * 3,
                      (t % 3 == 0) ? 16'hffff : ((t % 3 == 1) ? 16'h00f5 : 16'h8001), "R5");
        end
        jitter = 1'b1;
        ring_pass(9, 8'd17, 255, 16'h5a5a, "R6");
        jitter = 1'b0;

        // R7: threshold stall then resume
        wr(3'd4, 0);
        wr(3'd3, 0);
        codec_present = 16'hffff;
        rsp_count = 8'd3; rsp_thresh = 8'd3;
        exp_q.delete(); obs_q.delete();
        for (int i = 1; i <= 4; i++) begin
            ring_mem[i] = {4'(i), 1'b0, 7'(i + 40), 20'(i * 111)};
            exp_q.push_back(pack(ring_mem[i]));
        end
        exp_idx = 0;
        wr(3'd2, 4);
        wr(3'd4, 1);
        repeat (30) @(negedge clk);
        chk(ring_rp == 0, "R7", "stalled read pointer", ring_rp, 0);
        chk(obs_q.size() == 0, "R7", "stalled commands", obs_q.size(), 0);
        // R8: immediate bypasses the stall
        wr(3'd5, 32'h3050_0abc);
        wr(3'd6, 1);
        repeat (10) @(negedge clk);
        chk(obs_q.size() == 1, "R8", "immediate during stall count", obs_q.size(), 1);
        if (obs_q.size() == 1)
            chk(obs_q[0] == pack(32'h3050_0abc), "R8", "immediate fields", obs_q[0],
                pack(32'h3050_0abc));
        chk(!imm_busy, "R8", "busy cleared after dispatch", imm_busy, 0);
        obs_q.delete();
        rsp_count = 8'd0;
        wait_rp(8'd4);
        compare("R7", "resumed verbs");

        // R8: rejected immediate still clears busy
        obs_q.delete();
        wr(3'd5, 32'h2800_0001);
        wr(3'd6, 1);
        repeat (10) @(negedge clk);
        chk(obs_q.size() == 0, "R8", "indirect immediate dropped", obs_q.size(), 0);
        chk(!imm_busy, "R8", "busy cleared after reject", imm_busy, 0);

        // R8 R9: priority against a held ring verb
        hold_ready = 1'b1;
        exp_q.delete(); obs_q.delete();
        for (int i = 5; i <= 7; i++) ring_mem[i] = {4'(i), 1'b0, 7'(i), 20'(i * 7)};
        exp_idx = 4;
        wr(3'd2, 7);
        repeat (20) @(negedge clk);
        chk(cmd_valid == 1'b1, "R9", "ring verb held", cmd_valid, 1);
        rp_before = ring_rp;
        chk(rp_before == 8'd5, "R9", "no second fetch while held", rp_before, 5);
        wr(3'd5, 32'h1020_0555);
        wr(3'd6, 1);
        repeat (5) @(negedge clk);
        hold_ready = 1'b0;
        exp_q.push_back(pack(ring_mem[5]));
        exp_q.push_back(pack(32'h1020_0555));
        exp_q.push_back(pack(ring_mem[6]));
        exp_q.push_back(pack(ring_mem[7]));
        wait_rp(8'd7);
        compare("R8", "priority order");

        chk(!overlap_seen, "R9", "request while command pending", overlap_seen, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule